// File: doc/BRIEF.md
# Six-Channel Bit-Weighted PWM Bank

This block drives six independent 8-bit pulse-width outputs from a single shared segment counter. A repeat period is split into 256 equal segments. Each duty bit owns a fixed set of segments chosen so that its pulses are spread evenly across the period, and a channel is high in a segment when the duty bit owning that segment is set. The result is the OR of eight interleaved pulse trains. Their ripple frequency is much higher than that of a single ramp-compare pulse, which makes an external RC filter far easier to design.

The segment counter advances once every `SEG_DIV` strobes of the `seg_tick` input. With the default `SEG_DIV` = 2 and one strobe per clock, a segment lasts two clocks. At an 8 MHz clock a slower strobe gives a 4 µs segment and a 1024 µs period. Software writes the duty values, a control word and an output-enable mask through a simple write port. A duty write takes effect at the next output update and does not wait for a period boundary.

Top module: `pwm8_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all duty values, the control word and the enable mask clear to zero, and `pwm_out` and `pwm_oe` read all zeros after that edge.
- R2: While running, the segment index advances by one for every `SEG_DIV` accepted `seg_tick` strobes and wraps from 255 to 0, so one period is 256 segments regardless of how the strobes are spaced.
- R3: In segment c (c ≠ 0), an enabled, running, non-inverted channel is high exactly when duty bit (7 − t) is set, where t is the position of the lowest set bit of c. Duty bit 7 therefore covers every odd segment, and bit 0 covers only segment 128. Outputs are registered one clock after the segment index and settings they depend on.
- R4: Segment 0 is never active. Over one full period the number of active segments equals the duty value, so the range is 0 to 255 out of 256 and a fully high output cannot occur.
- R5: Writing address i (0 to 5) loads the duty value of channel i. The new value governs the very next output update, even in the middle of a period.
- R6: Bit 1 of the control word at address 6 inverts every enabled channel, so the output is high in inactive segments and low in active ones.
- R7: Bits 5:0 of the enable mask at address 7 set `pwm_oe[i]`, one clock after the write. A channel whose enable bit is 0 drives `pwm_out[i]` low.
- R8: Bit 0 of the control word stops counting when it is 1 and resets to 0. While it is 1, the segment index holds and every enabled output sits at its inactive level (low, or high when inverted). Clearing it resumes counting from the held segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_tick | input | 1 | Prescaled strobe that feeds the segment divider |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 to 5 duty, 6 control, 7 enable mask |
| wr_data | input | 8 | Write data |
| pwm_out | output | 6 | PWM outputs, one per channel |
| pwm_oe | output | 6 | Per-channel flag that the pin carries PWM rather than port data |

## Verification
The duty set 0, 255, 1, 128, 0x55 and 0xA3 is chosen so that an empty train, the densest train, the lone segment-128 pulse, the odd-segment train and two mixed patterns all run in one period. An error in the bit-to-segment mapping therefore shows up on one channel and not the others. The high-cycle count over one exact period is checked against the duty value, first in true polarity and then inverted, which separates a wrong weighting from a wrong polarity. Further phases rewrite a duty value mid-period, mask some channels, and stop and restart the counter under both polarities. A final phase uses irregular strobes from a shift register to show that counting depends only on accepted strobes.

// File: rtl/pwm8_pkg.sv
// Package: shared constants and the control-word type for the PWM bank.
// Assumes the control word is at least two bits wide.
package pwm8_pkg;
    // Bit positions inside the control word; software depends on these.
    localparam int CTL_STOP_BIT = 0;
    localparam int CTL_INV_BIT  = 1;

    // Decoded control settings shared by every channel.
    typedef struct packed {
        logic inv;
        logic stop;
    } pwm8_ctl_t;
endpackage

// File: rtl/pwm8_regs.sv
// Module: pwm8_regs
// Holds per-channel duty values, the control word and the output-enable mask.
// Addresses 0..NUM_CH-1 are duty values, NUM_CH is control, NUM_CH+1 the mask.
// Assumes NUM_CH <= DUTY_W so the mask fits in one write word.
module pwm8_regs
    import pwm8_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DUTY_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DUTY_W-1:0]        wr_data,
    output logic [NUM_CH*DUTY_W-1:0] duty_flat,
    output pwm8_ctl_t                ctl,
    output logic [NUM_CH-1:0]        chan_en
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_CH);
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(NUM_CH + 1);

    // Duty registers, one per channel, written by address match.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_duty
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)
                duty_flat[i*DUTY_W +: DUTY_W] <= '0;
            else if (wr_en && wr_addr == MY_ADDR)
                duty_flat[i*DUTY_W +: DUTY_W] <= wr_data;
        end
    end

    // Control word: stop and polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en && wr_addr == CTL_ADDR) begin
            ctl.stop <= wr_data[CTL_STOP_BIT];
            ctl.inv  <= wr_data[CTL_INV_BIT];
        end
    end

    // Output-enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chan_en <= '0;
        else if (wr_en && wr_addr == EN_ADDR)
            chan_en <= wr_data[NUM_CH-1:0];
    end
endmodule

// File: rtl/pwm8_seg_timer.sv
// Module: pwm8_seg_timer
// Divides accepted strobes by SEG_DIV and counts segments modulo 2**DUTY_W.
// Both the divider and the segment index hold while run is low.
module pwm8_seg_timer #(
    parameter int DUTY_W  = 8,
    parameter int SEG_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic [DUTY_W-1:0] seg
);
    localparam int DIV_W = (SEG_DIV > 1) ? $clog2(SEG_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SEG_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             step;

    assign step = run && tick && (div_q == DIV_LAST);

    // Strobe divider: counts accepted strobes within one segment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (run && tick)
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
    end

    // Segment index: one step per completed divide, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seg <= '0;
        else if (step)
            seg <= seg + 1'b1;
    end
endmodule

// File: rtl/pwm8_slot_sel.sv
// Module: pwm8_slot_sel
// Maps a segment index to a one-hot duty-bit select: bit k is chosen when
// the lowest set bit of seg sits at position DUTY_W-1-k. seg == 0 selects
// nothing. Purely combinational and shared by all channels.
module pwm8_slot_sel #(
    parameter int DUTY_W = 8
) (
    input  logic [DUTY_W-1:0] seg,
    output logic [DUTY_W-1:0] sel
);
    logic [DUTY_W-1:0] lower_any;

    // Prefix OR: lower_any[j] is set when any bit below j is set.
    assign lower_any[0] = 1'b0;
    for (genvar j = 1; j < DUTY_W; j++) begin : g_prefix
        assign lower_any[j] = lower_any[j-1] | seg[j-1];
    end

    // The lowest set bit of seg picks the mirrored duty-bit position.
    for (genvar j = 0; j < DUTY_W; j++) begin : g_sel
        assign sel[DUTY_W-1-j] = seg[j] & ~lower_any[j];
    end
endmodule

// File: rtl/pwm8_chan.sv
// Module: pwm8_chan
// One output channel: gates its duty value with the shared select, applies
// stop, polarity and enable, and registers the pin value and enable flag.
module pwm8_chan
    import pwm8_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] sel,
    input  logic [DUTY_W-1:0] duty,
    input  pwm8_ctl_t         ctl,
    input  logic              en,
    output logic              out_q,
    output logic              oe_q
);
    logic active;
    logic level;

    assign active = ~ctl.stop & (|(sel & duty));
    assign level  = active ^ ctl.inv;

    // Registered pin value and enable flag, aligned to the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
        end else begin
            out_q <= en & level;
            oe_q  <= en;
        end
    end
endmodule

// File: rtl/pwm8_bank.sv
// Module: pwm8_bank (top)
// Six bit-weighted PWM channels that share one segment counter and one
// segment-to-duty-bit decoder. Writes go straight into the live registers.
module pwm8_bank
    import pwm8_pkg::*;
#(
    parameter int NUM_CH  = 6,
    parameter int DUTY_W  = 8,
    parameter int SEG_DIV = 2,
    parameter int ADDR_W  = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);
    logic [NUM_CH*DUTY_W-1:0] duty_flat;
    pwm8_ctl_t                ctl;
    logic [NUM_CH-1:0]        chan_en;
    logic [DUTY_W-1:0]        seg_q;
    logic [DUTY_W-1:0]        sel;

    pwm8_regs #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .duty_flat(duty_flat), .ctl(ctl), .chan_en(chan_en)
    );

    pwm8_seg_timer #(.DUTY_W(DUTY_W), .SEG_DIV(SEG_DIV)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(~ctl.stop), .tick(seg_tick), .seg(seg_q)
    );

    pwm8_slot_sel #(.DUTY_W(DUTY_W)) u_sel (
        .seg(seg_q), .sel(sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm8_chan #(.DUTY_W(DUTY_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .sel(sel),
            .duty(duty_flat[i*DUTY_W +: DUTY_W]), .ctl(ctl),
            .en(chan_en[i]), .out_q(pwm_out[i]), .oe_q(pwm_oe[i])
        );
    end
endmodule

// File: rtl/pwm8_bank_chk.sv
// Module: pwm8_bank_chk
// Protocol checker bound into pwm8_bank; observes the segment index,
// the control settings, the duty values and the pins.
module pwm8_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int DUTY_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [DUTY_W-1:0]        seg,
    input logic                     stop,
    input logic                     inv,
    input logic [NUM_CH*DUTY_W-1:0] duty_flat,
    input logic [NUM_CH-1:0]        pwm_out,
    input logic [NUM_CH-1:0]        pwm_oe
);
    // R2: the segment index only ever moves forward by one.
    p_seg_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seg != $past(seg)) |-> (seg == $past(seg) + 1'b1));

    // R8: a stopped counter holds its segment.
    p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop) |-> (seg == $past(seg)));

    // R8: while stopped, enabled outputs sit at the inactive level.
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop) |-> (pwm_out == ({NUM_CH{$past(inv)}} & pwm_oe)));

    // R4: segment 0 is never active.
    p_seg0_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(seg) == '0) |-> (pwm_out == ({NUM_CH{$past(inv)}} & pwm_oe)));

    // R7: a disabled channel never drives high.
    p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~pwm_oe) == '0);

    // R3: odd segments follow the top duty bit of each channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_odd
        p_odd_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(seg[0]) && !$past(stop)) |->
            (pwm_out[i] == (pwm_oe[i] &
                ($past(duty_flat[i*DUTY_W + DUTY_W - 1]) ^ $past(inv)))));
    end
endmodule

bind pwm8_bank pwm8_bank_chk #(.NUM_CH(NUM_CH), .DUTY_W(DUTY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .seg(seg_q), .stop(ctl.stop), .inv(ctl.inv),
    .duty_flat(duty_flat), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
);

// File: tb/pwm8_bank_tb.sv
module pwm8_bank_tb;
    localparam int NCH = 6;
    localparam int SDIV = 2;
    localparam int PERIOD_CYC = 256 * SDIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       seg_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [5:0] pwm_out, pwm_oe;

    int    compared = 0;
    int    mismatched = 0;
    string cur_req = "R1";
    bit    checking = 1'b0;
    bit    finished = 1'b0;
    int    tick_mode = 0;
    logic [7:0] lfsr = 8'hA5;

    // Reference model state.
    int       m_seg = 0, m_div = 0;
    int       m_duty [NCH];
    bit       m_stop = 0, m_inv = 0;
    bit [5:0] m_en = '0;
    bit [5:0] exp_out = '0, exp_oe = '0;

    pwm8_bank #(.NUM_CH(NCH), .DUTY_W(8), .SEG_DIV(SDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .seg_tick(seg_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    always #5 clk = ~clk;

    // Strobe pattern: every clock, or irregular from a shift register.
    always @(negedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        seg_tick <= (tick_mode == 0) ? 1'b1 : (lfsr[1:0] == 2'b01);
    end

    // Behavioural model: outputs from the state before the edge, then update.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_seg = 0; m_div = 0; m_stop = 0; m_inv = 0; m_en = '0;
            exp_out = '0; exp_oe = '0;
            for (int c = 0; c < NCH; c++) m_duty[c] = 0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit act;
                act = 0;
                if (!m_stop && m_seg != 0) begin
                    int p;
                    p = 0;
                    while (((m_seg >> p) & 1) == 0) p++;
                    act = ((m_duty[c] >> (7 - p)) & 1) != 0;
                end
                exp_out[c] = m_en[c] ? (act ^ m_inv) : 1'b0;
            end
            exp_oe = m_en;
            if (!m_stop && seg_tick) begin
                if (m_div == SDIV - 1) begin
                    m_div = 0;
                    m_seg = (m_seg + 1) % 256;
                end else begin
                    m_div++;
                end
            end
            if (wr_en) begin
                if (wr_addr < NCH) m_duty[wr_addr] = wr_data;
                else if (wr_addr == 3'd6) begin
                    m_stop = wr_data[0];
                    m_inv  = wr_data[1];
                end else m_en = wr_data[5:0];
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (checking && rst_n) begin
            compared++;
            if (pwm_out !== exp_out || pwm_oe !== exp_oe) begin
                mismatched++;
                $display("FAIL %s: out=%b oe=%b expected out=%b oe=%b",
                         cur_req, pwm_out, pwm_oe, exp_out, exp_oe);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Counts high cycles per channel over one exact period.
    task automatic count_period(input string req, input bit inverted,
                                input int d0, input int d1, input int d2,
                                input int d3, input int d4, input int d5);
        int cnt [NCH];
        int dv [NCH];
        dv = '{d0, d1, d2, d3, d4, d5};
        for (int c = 0; c < NCH; c++) cnt[c] = 0;
        repeat (PERIOD_CYC) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) cnt[c] += pwm_out[c];
        end
        for (int c = 0; c < NCH; c++)
            check(req, cnt[c], (inverted ? 256 - dv[c] : dv[c]) * SDIV);
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        // R1: reset state, observed while reset is applied.
        rst_n = 1'b0;
        idle(4);
        check("R1 out", pwm_out, 0);
        check("R1 oe", pwm_oe, 0);
        rst_n = 1'b1;
        checking = 1'b1;
        idle(3);

        // R3 / R4: mixed duty set, all channels enabled, one strobe per clock.
        cur_req = "R3";
        wr(3'd0, 8'd0);   wr(3'd1, 8'd255); wr(3'd2, 8'd1);
        wr(3'd3, 8'd128); wr(3'd4, 8'h55);  wr(3'd5, 8'hA3);
        wr(3'd7, 8'h3F);
        idle(3);
        check("R7 oe mask", pwm_oe, 6'h3F);
        idle(PERIOD_CYC);
        cur_req = "R4";
        count_period("R4 high count", 1'b0, 0, 255, 1, 128, 8'h55, 8'hA3);

        // R6: inverted polarity.
        cur_req = "R6";
        wr(3'd6, 8'h02);
        idle(2);
        count_period("R6 inverted count", 1'b1, 0, 255, 1, 128, 8'h55, 8'hA3);

        // R5: duty rewrites in the middle of a period.
        cur_req = "R5";
        wr(3'd6, 8'h00);
        idle(77);
        wr(3'd0, 8'hFF);
        idle(41);
        wr(3'd2, 8'h0F);
        wr(3'd1, 8'h00);
        idle(PERIOD_CYC);

        // R7: partial enable mask.
        cur_req = "R7";
        wr(3'd7, 8'h15);
        idle(2);
        check("R7 partial oe", pwm_oe, 6'h15);
        idle(300);

        // R8: stop, non-inverted, then inverted, then resume.
        cur_req = "R8";
        wr(3'd7, 8'h3F);
        wr(3'd6, 8'h01);
        idle(3);
        check("R8 stopped low", pwm_out, 0);
        idle(100);
        check("R8 still low", pwm_out, 0);
        wr(3'd6, 8'h03);
        idle(3);
        check("R8 stopped inverted", pwm_out, 6'h3F);
        wr(3'd6, 8'h00);
        idle(PERIOD_CYC);

        // R2: irregular strobes.
        cur_req = "R2";
        tick_mode = 1;
        idle(3000);
        tick_mode = 0;
        idle(20);

        checking = 1'b0;
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule